// File: doc/BRIEF.md
# Clock Divider and Output Steering

This block turns the fast clock of a processor-rate PLL into processor and PCI clock outputs, and assigns them to a bank of ten outputs. Four outputs in that bank always carry the processor clock and four always carry the PCI clock. The remaining two can be switched into either group. The block also forwards a set of fixed-rate system clocks and a reference clock. It drives one tristate enable for each output pad. A skew option delays the PCI clocks by one fast-clock period relative to the processor clocks.

For board test, a bypass mode replaces every generated clock with a fixed division of the selected reference clock. The reference is either the crystal clock or an external test clock. The frequency-select inputs, the group select, the delay option and the shared-output select are each passed through a two-stage synchronizer in the clock domain of the logic they steer before they take effect.

Top module: `clkSteer`

## Requirements
- R1: With freqSel at 00, 01 or 10 (normal mode), every processor output has a period of four clkProcFast periods at 50% duty.
- R2: In normal mode every PCI output has a period of eight clkProcFast periods, which is half the processor frequency.
- R3: In normal mode with pciLag at 0, each PCI rising edge occurs at the same instant as a processor rising edge.
- R4: In normal mode with pciLag at 1, each PCI rising edge occurs exactly one clkProcFast period after a processor rising edge.
- R5: With freqSel at 11 (bypass mode), processor outputs run at the reference divided by 2 and PCI outputs at the reference divided by 4.
- R6: In bypass mode, q40 runs at the reference divided by 2, q24 at the reference divided by 4 and q12 at the reference divided by 8. The 16 MHz source runs at the reference divided by 6 and stays high for three reference periods.
- R7: In normal mode, q40, q24 and q12 carry sysClk40, sysClk24 and sysClk12, and the 16 MHz source is sysClk16.
- R8: qGroup[3:0] carry processor clocks and qGroup[9:6] carry PCI clocks. qGroup[5:4] carry processor clocks when grpSel is 0 and PCI clocks when grpSel is 1.
- R9: qShared carries the reference clock when sel16m is 0 and the 16 MHz source when sel16m is 1.
- R10: The reference is clkXtal when refSel is 0 and clkTest when refSel is 1. qRef14 always carries the reference.
- R11: All bits of padEn are 0 while outEn is 0 and 1 while outEn is 1, whatever the other selects are.
- R12: While rstN is low, all ten group outputs are held low, even with freqSel at 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkProcFast | input | 1 | Processor PLL output at four times the processor rate |
| clkXtal | input | 1 | Crystal oscillator clock |
| clkTest | input | 1 | External test reference clock |
| rstN | input | 1 | Active-low reset, applied synchronously in each domain |
| refSel | input | 1 | Reference source: 0 crystal, 1 test clock |
| freqSel | input | 2 | Processor frequency code; 11 selects bypass |
| grpSel | input | 1 | Assignment of the two swing outputs: 0 processor, 1 PCI |
| pciLag | input | 1 | 1 delays PCI clocks by one clkProcFast period |
| sel16m | input | 1 | Shared output source: 0 reference, 1 16 MHz |
| outEn | input | 1 | Output enable for all pads |
| sysClk16 | input | 1 | 16 MHz clock from the system PLL |
| sysClk24 | input | 1 | 24 MHz clock from the system PLL |
| sysClk12 | input | 1 | 12 MHz clock from the system PLL |
| sysClk40 | input | 1 | 40 MHz clock from the system PLL |
| qGroup | output | 10 | Processor/PCI output bank |
| qRef14 | output | 1 | Reference clock output |
| qShared | output | 1 | Shared reference/16 MHz output |
| q24 | output | 1 | 24 MHz output |
| q12 | output | 1 | 12 MHz output |
| q40 | output | 1 | 40 MHz output |
| padEn | output | 15 | Tristate enable for each output pad |

## Verification
Rising-edge periods of all fifteen outputs are measured under each of the three normal frequency codes and under bypass driven from both reference sources. The checks flip the group select and the shared-output select between rows. This separates a swing output that follows the wrong group, a shared output fed from the wrong source, and a bypass divider with the wrong ratio, because each of these faults gives a period different from the expected one. Directed tests measure the offset from a processor edge to the next PCI edge with the delay option off and on. They also measure the high time of the divide-by-6 clock to catch a duty error, and they hold reset while bypass is requested.

// File: rtl/clkSteerPkg.sv
`timescale 1ns/1ps
package clkSteerPkg;
  // Strobes passed from control to datapath, already synchronized
  typedef struct packed {
    logic testMode;  // bypass dividers drive every output (ref domain)
    logic grpPci;    // swing outputs join the PCI group (ref domain)
    logic sel16;     // shared output carries 16 MHz source (ref domain)
    logic pciLag;    // PCI delayed by one fast period (proc domain)
  } steerCtrl_t;
endpackage

// File: rtl/syncBits.sv
`timescale 1ns/1ps
module syncBits #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/steerCtrl.sv
`timescale 1ns/1ps
module steerCtrl
  import clkSteerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkRef,
  input  logic       clkProcFast,
  input  logic       rstN,
  input  logic [1:0] freqSel,
  input  logic       grpSel,
  input  logic       sel16m,
  input  logic       pciLag,
  output steerCtrl_t ctrl
);
  localparam int REF_BITS = 3;

  logic                testReq;
  logic [REF_BITS-1:0] refSyncQ;
  logic                lagSyncQ;

  // Only the all-ones code changes this block's behaviour
  assign testReq = &freqSel;

  syncBits #(.W(REF_BITS), .STAGES(SYNC_STAGES)) i_refSync (
    .clk  (clkRef),
    .rstN (rstN),
    .d    ({testReq, grpSel, sel16m}),
    .q    (refSyncQ)
  );

  syncBits #(.W(1), .STAGES(SYNC_STAGES)) i_lagSync (
    .clk  (clkProcFast),
    .rstN (rstN),
    .d    (pciLag),
    .q    (lagSyncQ)
  );

  assign ctrl.testMode = refSyncQ[2];
  assign ctrl.grpPci   = refSyncQ[1];
  assign ctrl.sel16    = refSyncQ[0];
  assign ctrl.pciLag   = lagSyncQ;
endmodule

// File: rtl/steerDatapath.sv
`timescale 1ns/1ps
module steerDatapath
  import clkSteerPkg::*;
#(
  parameter int N_CORE  = 4,
  parameter int N_SWING = 2,
  parameter int N_PCI   = 4,
  localparam int N_GROUP = N_CORE + N_SWING + N_PCI
) (
  input  logic               clkProcFast,
  input  logic               clkRef,
  input  logic               rstN,
  input  steerCtrl_t         ctrl,
  input  logic               sysClk16,
  input  logic               sysClk24,
  input  logic               sysClk12,
  input  logic               sysClk40,
  output logic [N_GROUP-1:0] qGroup,
  output logic               qShared,
  output logic               q24,
  output logic               q12,
  output logic               q40
);
  localparam int PCNT_W = 3;  // proc /4 and PCI /8 from one counter
  localparam int RCNT_W = 3;  // bypass /2, /4, /8 from one counter
  localparam int M3_W   = 2;

  // ---------------- processor domain ----------------
  logic [PCNT_W-1:0] pCnt, pNext;
  logic              procQ, pciQ, pciDlyQ, pciSel;

  assign pNext = pCnt + 1'b1;

  always_ff @(posedge clkProcFast) begin
    if (!rstN) begin
      pCnt    <= '0;
      procQ   <= 1'b0;
      pciQ    <= 1'b0;
      pciDlyQ <= 1'b0;
    end else begin
      pCnt    <= pNext;
      procQ   <= ~pNext[1];   // rises at pNext 0 and 4
      pciQ    <= pNext[2];    // rises at pNext 4, with procQ
      pciDlyQ <= pciQ;
    end
  end

  assign pciSel = ctrl.pciLag ? pciDlyQ : pciQ;

  // ---------------- reference (bypass) domain ----------------
  logic [RCNT_W-1:0] rCnt, rNext;
  logic [M3_W-1:0]   m3Cnt;
  logic              rDiv2Q, rDiv4Q, rDiv8Q, rDiv6Q;

  assign rNext = rCnt + 1'b1;

  always_ff @(posedge clkRef) begin
    if (!rstN) begin
      rCnt   <= '0;
      rDiv2Q <= 1'b0;
      rDiv4Q <= 1'b0;
      rDiv8Q <= 1'b0;
    end else begin
      rCnt   <= rNext;
      rDiv2Q <= rNext[0];
      rDiv4Q <= rNext[1];
      rDiv8Q <= rNext[2];
    end
  end

  // divide by 6: toggle every third reference edge
  always_ff @(posedge clkRef) begin
    if (!rstN) begin
      m3Cnt  <= '0;
      rDiv6Q <= 1'b0;
    end else if (m3Cnt == M3_W'(2)) begin
      m3Cnt  <= '0;
      rDiv6Q <= ~rDiv6Q;
    end else begin
      m3Cnt  <= m3Cnt + 1'b1;
    end
  end

  // ---------------- steering ----------------
  logic procSrc, pciSrc, src16;

  assign procSrc = ctrl.testMode ? rDiv2Q : procQ;
  assign pciSrc  = ctrl.testMode ? rDiv4Q : pciSel;
  assign src16   = ctrl.testMode ? rDiv6Q : sysClk16;

  for (genvar g = 0; g < N_GROUP; g++) begin : g_out
    if (g < N_CORE) begin : g_core
      assign qGroup[g] = procSrc;
    end else if (g < N_CORE + N_SWING) begin : g_swing
      assign qGroup[g] = ctrl.grpPci ? pciSrc : procSrc;
    end else begin : g_pci
      assign qGroup[g] = pciSrc;
    end
  end

  assign qShared = ctrl.sel16 ? src16 : clkRef;
  assign q24     = ctrl.testMode ? rDiv4Q : sysClk24;
  assign q12     = ctrl.testMode ? rDiv8Q : sysClk12;
  assign q40     = ctrl.testMode ? rDiv2Q : sysClk40;
endmodule

// File: rtl/clkSteer.sv
`timescale 1ns/1ps
module clkSteer
  import clkSteerPkg::*;
#(
  parameter int N_CORE      = 4,
  parameter int N_SWING     = 2,
  parameter int N_PCI       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int N_GROUP = N_CORE + N_SWING + N_PCI,
  localparam int N_PAD   = N_GROUP + 5
) (
  input  logic               clkProcFast,
  input  logic               clkXtal,
  input  logic               clkTest,
  input  logic               rstN,
  input  logic               refSel,
  input  logic [1:0]         freqSel,
  input  logic               grpSel,
  input  logic               pciLag,
  input  logic               sel16m,
  input  logic               outEn,
  input  logic               sysClk16,
  input  logic               sysClk24,
  input  logic               sysClk12,
  input  logic               sysClk40,
  output logic [N_GROUP-1:0] qGroup,
  output logic               qRef14,
  output logic               qShared,
  output logic               q24,
  output logic               q12,
  output logic               q40,
  output logic [N_PAD-1:0]   padEn
);
  logic       clkRef;
  steerCtrl_t ctrl;

  assign clkRef = refSel ? clkTest : clkXtal;
  assign qRef14 = clkRef;
  assign padEn  = {N_PAD{outEn}};

  steerCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clkRef      (clkRef),
    .clkProcFast (clkProcFast),
    .rstN        (rstN),
    .freqSel     (freqSel),
    .grpSel      (grpSel),
    .sel16m      (sel16m),
    .pciLag      (pciLag),
    .ctrl        (ctrl)
  );

  steerDatapath #(.N_CORE(N_CORE), .N_SWING(N_SWING), .N_PCI(N_PCI)) i_dp (
    .clkProcFast (clkProcFast),
    .clkRef      (clkRef),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .sysClk16    (sysClk16),
    .sysClk24    (sysClk24),
    .sysClk12    (sysClk12),
    .sysClk40    (sysClk40),
    .qGroup      (qGroup),
    .qShared     (qShared),
    .q24         (q24),
    .q12         (q12),
    .q40         (q40)
  );
endmodule

// File: rtl/clkSteerChecker.sv
`timescale 1ns/1ps
module clkSteerChecker #(
  parameter int N_CORE  = 4,
  parameter int N_GROUP = 10,
  parameter int N_PAD   = 15
) (
  input logic               clkProcFast,
  input logic               rstN,
  input logic               outEn,
  input logic [N_PAD-1:0]   padEn,
  input logic [N_GROUP-1:0] qGroup,
  input logic               ctrlTest,
  input logic               ctrlGrp,
  input logic               ctrlLag
);
  logic normAligned, normLagged;
  assign normAligned = !ctrlTest && !ctrlLag;
  assign normLagged  = !ctrlTest && ctrlLag;

  a_r11_pads_off: assert property (@(posedge clkProcFast) disable iff (!rstN)
    !outEn |-> padEn == '0);

  a_r11_pads_on: assert property (@(posedge clkProcFast) disable iff (!rstN)
    outEn |-> &padEn);

  a_r3_pci_aligned: assert property (@(posedge clkProcFast) disable iff (!rstN)
    (normAligned && $past(normAligned) && $rose(qGroup[N_GROUP-1]))
      |-> $rose(qGroup[0]));

  a_r4_pci_lagged: assert property (@(posedge clkProcFast) disable iff (!rstN)
    (normLagged && $past(normLagged) && $past(normLagged, 2) && $rose(qGroup[N_GROUP-1]))
      |-> ($past(qGroup[0]) && !$past(qGroup[0], 2)));

  a_r8_core_uniform: assert property (@(posedge clkProcFast) disable iff (!rstN)
    $countones(qGroup[N_CORE-1:0]) == 0 || $countones(qGroup[N_CORE-1:0]) == N_CORE);

  a_r8_swing_pci: assert property (@(posedge clkProcFast) disable iff (!rstN)
    ctrlGrp |-> qGroup[N_CORE] == qGroup[N_GROUP-1]);

  a_r8_swing_proc: assert property (@(posedge clkProcFast) disable iff (!rstN)
    !ctrlGrp |-> qGroup[N_CORE] == qGroup[0]);
endmodule

bind clkSteer clkSteerChecker #(
  .N_CORE  (N_CORE),
  .N_GROUP (N_GROUP),
  .N_PAD   (N_PAD)
) i_clkSteerChecker (
  .clkProcFast (clkProcFast),
  .rstN        (rstN),
  .outEn       (outEn),
  .padEn       (padEn),
  .qGroup      (qGroup),
  .ctrlTest    (ctrl.testMode),
  .ctrlGrp     (ctrl.grpPci),
  .ctrlLag     (ctrl.pciLag)
);

// File: tb/test_clkSteer.sv
`timescale 1ns/1ps
module test_clkSteer;
  localparam realtime T_FAST = 4.0;    // 250 MHz
  localparam realtime T_TEST = 10.0;
  localparam realtime T_XTAL = 70.0;
  localparam realtime T_S16  = 62.0;
  localparam realtime T_S24  = 42.0;
  localparam realtime T_S12  = 84.0;
  localparam realtime T_S40  = 25.0;

  logic clkProcFast = 0, clkXtal = 0, clkTest = 0;
  logic sysClk16 = 0, sysClk24 = 0, sysClk12 = 0, sysClk40 = 0;
  logic rstN = 0, refSel = 0, grpSel = 0, pciLag = 0, sel16m = 0, outEn = 1;
  logic [1:0] freqSel = 2'b00;
  logic [9:0] qGroup;
  logic qRef14, qShared, q24, q12, q40;
  logic [14:0] padEn;
  wire  [14:0] allOut = {q40, q12, q24, qShared, qRef14, qGroup};

  always #(T_FAST/2) clkProcFast = ~clkProcFast;
  always #(T_XTAL/2) clkXtal     = ~clkXtal;
  always #(T_TEST/2) clkTest     = ~clkTest;
  always #(T_S16/2)  sysClk16    = ~sysClk16;
  always #(T_S24/2)  sysClk24    = ~sysClk24;
  always #(T_S12/2)  sysClk12    = ~sysClk12;
  always #(T_S40/2)  sysClk40    = ~sysClk40;

  clkSteer i_clkSteer (
    .clkProcFast, .clkXtal, .clkTest, .rstN, .refSel, .freqSel, .grpSel,
    .pciLag, .sel16m, .outEn, .sysClk16, .sysClk24, .sysClk12, .sysClk40,
    .qGroup, .qRef14, .qShared, .q24, .q12, .q40, .padEn
  );

  int checks = 0, fails = 0;
  bit done = 0;
  realtime lastProcRise = 0;
  always @(posedge qGroup[0]) lastProcRise = $realtime;

  typedef struct packed {
    logic [1:0] fs;
    logic grp;
    logic s16;
    logic rsel;
    int procPs;
    int pciPs;
    int sharedPs;
    int refPs;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0,  16000,  32000,  70000, 70000},
    '{2'b01, 1'b1, 1'b1, 1'b0,  16000,  32000,  62000, 70000},
    '{2'b10, 1'b0, 1'b1, 1'b1,  16000,  32000,  62000, 10000},
    '{2'b11, 1'b0, 1'b1, 1'b1,  20000,  40000,  60000, 10000},
    '{2'b11, 1'b1, 1'b0, 1'b1,  20000,  40000,  10000, 10000},
    '{2'b11, 1'b1, 1'b1, 1'b0, 140000, 280000, 420000, 70000}
  };

  task automatic checkTime(string req, string what, realtime got, realtime exp);
    checks++;
    if (got < exp - 0.05 || got > exp + 0.05) begin
      fails++;
      $display("FAIL %s %s: actual %0.3f ns expected %0.3f ns", req, what, got, exp);
    end
  endtask

  task automatic checkBits(string req, string what, logic [14:0] got, logic [14:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic risePeriod(input int idx, output realtime per);
    realtime t1;
    wait (allOut[idx] == 1'b0);
    wait (allOut[idx] == 1'b1);
    t1 = $realtime;
    wait (allOut[idx] == 1'b0);
    wait (allOut[idx] == 1'b1);
    per = $realtime - t1;
  endtask

  task automatic lagOffset(input int idx, output realtime off);
    realtime tp;
    wait (allOut[idx] == 1'b0);
    wait (allOut[idx] == 1'b1);
    tp = $realtime;
    #0.5;
    off = tp - lastProcRise;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    realtime per, off, tHi;
    bit test;
    // R12: reset holds group low even with bypass requested
    freqSel = 2'b11;
    #200;
    checkBits("R12", "group during reset", {5'b0, qGroup}, 15'h0);
    #1;
    rstN = 1;
    freqSel = 2'b00;
    #1000;

    // table walk
    foreach (VECS[v]) begin
      freqSel = VECS[v].fs;
      grpSel  = VECS[v].grp;
      sel16m  = VECS[v].s16;
      refSel  = VECS[v].rsel;
      test    = (VECS[v].fs == 2'b11);
      #3000;
      for (int i = 0; i < 10; i++) begin
        bit isPci;
        string tag;
        isPci = (i >= 6) || (i >= 4 && VECS[v].grp);
        if (i == 4 || i == 5) tag = "R8";
        else if (test) tag = "R5";
        else tag = isPci ? "R2" : "R1";
        risePeriod(i, per);
        checkTime(tag, $sformatf("row %0d qGroup[%0d] period", v, i), per,
                  (isPci ? VECS[v].pciPs : VECS[v].procPs) / 1000.0);
      end
      risePeriod(10, per);
      checkTime("R10", $sformatf("row %0d qRef14 period", v), per, VECS[v].refPs / 1000.0);
      risePeriod(11, per);
      checkTime("R9", $sformatf("row %0d qShared period", v), per, VECS[v].sharedPs / 1000.0);
      risePeriod(12, per);
      checkTime(test ? "R6" : "R7", $sformatf("row %0d q24 period", v), per,
                test ? 4.0 * VECS[v].refPs / 1000.0 : T_S24);
      risePeriod(13, per);
      checkTime(test ? "R6" : "R7", $sformatf("row %0d q12 period", v), per,
                test ? 8.0 * VECS[v].refPs / 1000.0 : T_S12);
      risePeriod(14, per);
      checkTime(test ? "R6" : "R7", $sformatf("row %0d q40 period", v), per,
                test ? 2.0 * VECS[v].refPs / 1000.0 : T_S40);
    end

    // R6: divide-by-6 high time in bypass (test reference, 16 MHz selected)
    freqSel = 2'b11; refSel = 1; sel16m = 1;
    #2000;
    wait (qShared == 1'b0);
    wait (qShared == 1'b1);
    tHi = $realtime;
    wait (qShared == 1'b0);
    checkTime("R6", "div6 high time", $realtime - tHi, 3.0 * T_TEST);

    // R3 / R4: PCI offset from processor edge
    freqSel = 2'b00; refSel = 0; grpSel = 1; pciLag = 0;
    #2000;
    lagOffset(9, off);
    checkTime("R3", "pci offset lag off", off, 0.0);
    lagOffset(4, off);
    checkTime("R3", "swing pci offset lag off", off, 0.0);
    pciLag = 1;
    #2000;
    lagOffset(9, off);
    checkTime("R4", "pci offset lag on", off, T_FAST);
    lagOffset(4, off);
    checkTime("R4", "swing pci offset lag on", off, T_FAST);
    risePeriod(9, per);
    checkTime("R2", "pci period lag on", per, 8.0 * T_FAST);
    pciLag = 0;
    grpSel = 0;

    // R11: pad enables follow outEn in any mode
    foreach (VECS[v]) begin
      freqSel = VECS[v].fs;
      grpSel  = VECS[v].grp;
      outEn   = 0;
      #7;
      checkBits("R11", $sformatf("padEn off row %0d", v), padEn, 15'h0000);
      outEn   = 1;
      #7;
      checkBits("R11", $sformatf("padEn on row %0d", v), padEn, 15'h7fff);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule